// File: doc/BRIEF.md
# Token-Passing FIFO Depth Cascade

This block builds one deep first-in/first-out buffer out of a ring of identical storage slices, with no address shared between them. Each slice owns a small memory, its own write and read pointers and an occupancy count. Two tokens travel around the ring: the write token marks the slice that takes the next stored word, and the read token marks the slice that gives up the next word. A strobe on the shared write or read input reaches memory only in the slice that holds the matching token.

When a slice stores into, or hands out from, its last physical location, it raises an expansion pulse for that direction. The next slice in the ring sees that pulse and takes the token in the same clock, so streaming continues with no idle cycle. The last slice feeds the first. A per-slice first-load input, active low, picks the slice that holds both tokens after reset. The composite empty flag is the empty state of the slice holding the read token. The composite full flag is the full state of the slice holding the write token. Read data comes from a register in the slice that served the last read, and only that slice drives the shared output.

Top module: `token_ring_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, every slice returns to location zero with nothing stored. After reset `empty`=1, `full`=0, `rd_valid`=0 and `rd_data`=0.
- R2: Words come out in the order they were accepted, across slice boundaries and around the ring. A read accepted in cycle t shows its word on `rd_data` with `rd_valid`=1 after the clock edge that ends cycle t.
- R3: After NUM_SLICES*SLICE_DEPTH accepted writes with no reads, `full` is 1. A write strobe while `full` is 1 stores nothing, and later reads show no trace of it.
- R4: `empty` is 1 exactly when every accepted word has been read. A read strobe while `empty` is 1 is ignored: `rd_valid` stays 0 in the next cycle and `rd_data` keeps its value.
- R5: Bit k of `xo_wr` is 1 during a cycle with an accepted write exactly when that write lands in slice k's last location. Counting accepted writes from 0 after reset, write number n lands in slice (S + n/SLICE_DEPTH) mod NUM_SLICES at location n mod SLICE_DEPTH, where S is the start slice.
- R6: `xo_rd` follows the same rule as R5 for accepted reads, with read number n taking the place of write number n.
- R7: The start slice S is the single slice whose `first_load_n` bit is 0 at reset. That slice holds both tokens at first.
- R8: When the buffer is neither empty nor full, a write and a read in the same cycle both take effect, and the number of stored words does not change.
- R9: When `full` is 1 and both strobes are high, the read is accepted and the write is dropped. `full` is 0 in the next cycle.
- R10: When no read is accepted, `rd_valid` is 0 in the next cycle and `rd_data` keeps the last word read.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| first_load_n | input | NUM_SLICES | Active-low start-slice select, exactly one bit 0 |
| wr_en | input | 1 | Write strobe, shared by all slices |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read strobe, shared by all slices |
| rd_data | output | DATA_W | Word from the last accepted read |
| rd_valid | output | 1 | 1 in the cycle after an accepted read |
| empty | output | 1 | Composite empty flag |
| full | output | 1 | Composite full flag |
| xo_wr | output | NUM_SLICES | Per-slice write expansion pulses |
| xo_rd | output | NUM_SLICES | Per-slice read expansion pulses |

## Verification
The hardest case to reach from the ports is a token handoff that happens while the read token and the write token sit in the same slice at opposite ends of its memory. This happens in a full or nearly empty chain, after the ring has wrapped at least once and away from the reset start slice. The bench reaches it by running every start slice through fill-to-full, over-fill, a read that coincides with a write on a full chain, drain, and over-drain. It then runs a long mixed phase whose write and read densities shift arithmetically, so occupancy crosses both limits many times after the tokens have lapped the ring. Every cycle is compared with a bench model built on accepted-word counters, which predicts the flags, the expansion pulse positions and the read data.

// File: rtl/token_ring_pkg.sv
package token_ring_pkg;
  // token handoff pulses carried from one slice to the next
  typedef struct packed {
    logic wr;
    logic rd;
  } tok_pulse_t;
endpackage

// File: rtl/ring_slice.sv
module ring_slice
  import token_ring_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SLICE_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              first_load_n,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] wr_data,
  input  tok_pulse_t        tok_in,
  output tok_pulse_t        tok_out,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_own,
  output logic              empty_n,
  output logic              full_n,
  output logic              wr_tok,
  output logic              rd_tok
);
  localparam int PW = (SLICE_DEPTH > 1) ? $clog2(SLICE_DEPTH) : 1;
  localparam int CW = $clog2(SLICE_DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(SLICE_DEPTH - 1);

  logic [DATA_W-1:0] mem [SLICE_DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic my_wr, my_rd, w_last, r_last;

  assign my_wr   = wr_go & wr_tok;
  assign my_rd   = rd_go & rd_tok;
  assign w_last  = (wptr == LAST);
  assign r_last  = (rptr == LAST);
  assign tok_out.wr = my_wr & w_last;
  assign tok_out.rd = my_rd & r_last;
  assign empty_n = (cnt != '0);
  assign full_n  = (cnt != CW'(SLICE_DEPTH));

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (my_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (my_rd) rd_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      wr_tok <= ~first_load_n;
      rd_tok <= ~first_load_n;
      rd_own <= 1'b0;
    end else begin
      if (my_wr) wptr <= w_last ? '0 : wptr + 1'b1;
      if (my_rd) rptr <= r_last ? '0 : rptr + 1'b1;
      case ({my_wr, my_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      wr_tok <= (wr_tok & ~tok_out.wr) | tok_in.wr;
      rd_tok <= (rd_tok & ~tok_out.rd) | tok_in.rd;
      if (rd_go) rd_own <= my_rd;
    end
  end

  // R3
  slice_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(SLICE_DEPTH));
  // R5
  wr_token_arrive_chk: assert property (@(posedge clk) disable iff (rst)
    tok_in.wr |=> (wptr == '0) && wr_tok);
  // R6
  rd_token_arrive_chk: assert property (@(posedge clk) disable iff (rst)
    tok_in.rd |=> (rptr == '0) && rd_tok);
endmodule

// File: rtl/token_ring_fifo.sv
module token_ring_fifo
  import token_ring_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SLICE_DEPTH = 4,
  parameter int NUM_SLICES  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SLICES-1:0] first_load_n,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic                  empty,
  output logic                  full,
  output logic [NUM_SLICES-1:0] xo_wr,
  output logic [NUM_SLICES-1:0] xo_rd
);
  tok_pulse_t              tok_out [NUM_SLICES];
  logic [DATA_W-1:0]       slice_q [NUM_SLICES];
  logic [NUM_SLICES-1:0]   rd_own, empty_n, full_n, wr_tok, rd_tok;
  logic                    wr_go, rd_go;

  // governing flag: the slice that holds the token for that direction
  assign full  = |(wr_tok & ~full_n);
  assign empty = |(rd_tok & ~empty_n);
  assign wr_go = wr_en & ~full;
  assign rd_go = rd_en & ~empty;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    localparam int PREV = (k + NUM_SLICES - 1) % NUM_SLICES;
    ring_slice #(.DATA_W(DATA_W), .SLICE_DEPTH(SLICE_DEPTH)) u_slice (
      .clk          (clk),
      .rst          (rst),
      .first_load_n (first_load_n[k]),
      .wr_go        (wr_go),
      .rd_go        (rd_go),
      .wr_data      (wr_data),
      .tok_in       (tok_out[PREV]),
      .tok_out      (tok_out[k]),
      .rd_q         (slice_q[k]),
      .rd_own       (rd_own[k]),
      .empty_n      (empty_n[k]),
      .full_n       (full_n[k]),
      .wr_tok       (wr_tok[k]),
      .rd_tok       (rd_tok[k])
    );
    assign xo_wr[k] = tok_out[k].wr;
    assign xo_rd[k] = tok_out[k].rd;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_SLICES; k++)
      if (rd_own[k]) rd_data = rd_data | slice_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_go;
  end

  // R7
  wr_tok_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_tok) == 1);
  // R7
  rd_tok_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_tok) == 1);
  // R2
  rd_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_own));
  // R3
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> !rd_valid);
  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_en) |=> full);
endmodule

// File: tb/token_ring_fifo_bench.sv
module token_ring_fifo_bench;
  localparam int DW  = 8;
  localparam int D   = 4;
  localparam int N   = 3;
  localparam int CAP = D * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] first_load_n = '1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, empty, full;
  logic [N-1:0] xo_wr, xo_rd;

  int checks = 0, errors = 0;
  int s_start, wtot, rtot, cnt;
  logic [DW-1:0] model [CAP];
  logic [DW-1:0] last_rd;
  logic [DW-1:0] dval;

  always #4 clk = ~clk;

  token_ring_fifo #(.DATA_W(DW), .SLICE_DEPTH(D), .NUM_SLICES(N)) u_token_ring_fifo (
    .clk(clk), .rst(rst), .first_load_n(first_load_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty), .full(full),
    .xo_wr(xo_wr), .xo_rd(xo_rd)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int s);
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    first_load_n = '1;
    first_load_n[s] = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    s_start = s; wtot = 0; rtot = 0; cnt = 0; last_rd = '0;
    #1;
    chk(empty == 1'b1, "R1 empty", int'(empty), 1);
    chk(full == 1'b0, "R1 full", int'(full), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    chk(rd_data == '0, "R1 rd_data", int'(rd_data), 0);
  endtask

  task automatic step(input logic w, input logic r);
    logic acc_w, acc_r;
    logic [N-1:0] exw, exr;
    logic [DW-1:0] exp_d;
    int cnt_before;
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = dval;
    #2;
    acc_r = r && (cnt > 0);
    acc_w = w && (cnt < CAP);
    cnt_before = cnt;
    chk(empty == (cnt == 0), "R4 empty flag", int'(empty), int'(cnt == 0));
    chk(full == (cnt == CAP), "R3 full flag", int'(full), int'(cnt == CAP));
    exw = '0; exr = '0;
    if (acc_w && (wtot % D == D - 1)) exw[(s_start + wtot / D) % N] = 1'b1;
    if (acc_r && (rtot % D == D - 1)) exr[(s_start + rtot / D) % N] = 1'b1;
    chk(xo_wr == exw, "R5 R7 xo_wr", int'(xo_wr), int'(exw));
    chk(xo_rd == exr, "R6 xo_rd", int'(xo_rd), int'(exr));
    exp_d = model[rtot % CAP];
    if (acc_w) begin model[wtot % CAP] = dval; wtot++; cnt++; end
    if (acc_r) begin rtot++; cnt--; last_rd = exp_d; end
    if (acc_w && acc_r) chk(cnt == cnt_before, "R8 occupancy", cnt, cnt_before);
    @(posedge clk);
    #1;
    if (acc_r) begin
      chk(rd_valid == 1'b1, "R2 rd_valid", int'(rd_valid), 1);
      chk(rd_data == exp_d, "R2 order", int'(rd_data), int'(exp_d));
    end else begin
      chk(rd_valid == 1'b0, "R10 R4 no read", int'(rd_valid), 0);
      chk(rd_data == last_rd, "R10 hold", int'(rd_data), int'(last_rd));
    end
    if (w && r && cnt_before == CAP)
      chk(full == 1'b0, "R9 full drops", int'(full), 0);
    dval = dval + 8'd37;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    dval = 8'h11;
    for (int s = 0; s < N; s++) begin
      do_reset(s);
      // R3: fill to capacity, then try to overfill
      for (int i = 0; i < CAP + 2; i++) step(1'b1, 1'b0);
      // R9: read and write together on a full chain
      step(1'b1, 1'b1);
      // R3: the dropped write must not appear on drain; R4: over-drain
      for (int i = 0; i < CAP + 2; i++) step(1'b0, 1'b1);
      // R8: streaming with one word held
      step(1'b1, 1'b0);
      for (int i = 0; i < 2 * CAP + 3; i++) step(1'b1, 1'b1);
      // mixed phase, write-heavy then read-heavy
      for (int i = 0; i < 400; i++)
        step(((i * 7 + s) % 5) != 0, ((i * 3 + s) % 4) == 0);
      for (int i = 0; i < 400; i++)
        step(((i * 5 + s) % 4) == 0, ((i * 11 + s) % 7) != 0);
      for (int i = 0; i < 300; i++)
        step(((i * 13 + s) % 3) != 0, ((i * 17 + s) % 5) < 3);
    end
    // R1: a reset in the middle of traffic clears the chain
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    do_reset(1);
    step(1'b0, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule